// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block turns three real-time-clock event sources into one interrupt request. The sources are a rising edge on a selectable tap of the clock divider chain (periodic), a match between the freshly updated time and a stored alarm time (alarm), and the once-per-second time update itself (update). Each source latches a sticky flag. A per-source enable bit decides whether that flag drives the interrupt output. Software sees the enables in a control register and the flags in a read-only status register. Reading the status register clears the flags.

A small sequencer tracks whether the clock is running. It has three named states. `ST_OFF` is held while the RTC is in reset or disabled. `ST_RUN` is normal operation. `ST_CMP` lasts one cycle after each update strobe, and the alarm comparison is made in it. The transitions are:

- OFF→RUN (`go`): the enable is high and the RTC reset is low.
- RUN→CMP (`update`): an update strobe arrives.
- CMP→RUN (`compared`): no new strobe arrives.
- CMP→CMP (`update`): another strobe arrives.
- Any state→OFF (`halt`): RTC reset or disable.

Periodic and update logic are cleared by RTC reset or disable. Alarm logic is gated only by a valid-RAM status bit.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: `irq` equals (UIE and UF) or (AIE and AF) or (PIE and PF). Status bit 7 returns the value `irq` had in the read cycle.
- R2: A read with `reg_sel`=1 returns, one cycle later on `reg_rdata`, the status layout {bit7 irq, bit6 PF, bit5 AF, bit4 UF, bits3:0 zero}. The same read clears PF, AF and UF.
- R3: With `rate_sel`=k (1..15), PF sets on a rising edge of `div_taps[k-1]`. Edges on other taps and falling edges have no effect.
- R4: AF sets one cycle after the sequencer enters `ST_CMP`. This happens only when, in the cycle after the update strobe, all five current fields (seconds, minutes, hours, date, month) equal their alarm fields.
- R5: UF sets on every update strobe seen while the sequencer is not in `ST_OFF`.
- R6: While `rtc_rst`=1 or `rtc_en`=0, PIE, UIE, PF and UF are cleared, and writes cannot set PIE or UIE. Running resumes one cycle after `rtc_en`=1 and `rtc_rst`=0.
- R7: While `ram_valid`=0, AIE and AF are held at 0. RTC reset and disable do not clear AIE or AF.
- R8: The control register (`reg_sel`=0) has bit6 PIE, bit5 AIE, bit4 UIE, and bit3 always reading 0. Bits 7, 2, 1 and 0 are plain storage cleared only by `rst_n`. Writes with `reg_sel`=1 have no effect.
- R9: If an event sets a flag in the same cycle as a status read, the flag stays set. The read returns the value from before the event.
- R10: `rate_sel`=0 never sets PF.
- R11: Flags latch whatever their enables are. Only `irq` is gated by the enables.
- R12: Events are ignored in `ST_OFF`, and the alarm is compared only in `ST_CMP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| rtc_rst | input | 1 | RTC hardware/software reset, active high |
| rtc_en | input | 1 | RTC enable |
| ram_valid | input | 1 | Valid-RAM status; 0 gates alarm logic |
| upd_stb | input | 1 | One-cycle time update strobe |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| cur_date | input | 8 | Current date |
| cur_mon | input | 8 | Current month |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours |
| alm_date | input | 8 | Alarm date |
| alm_mon | input | 8 | Alarm month |
| div_taps | input | 15 | Divider chain taps |
| rate_sel | input | 4 | Periodic rate select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `upd_stb` is a single-cycle pulse.
- The time fields are stable in the cycle after the strobe.
- `reg_rd` and `reg_wr` are never high together.
- `rate_sel` is steady around a tap edge.

The directed stimulus respects these assumptions. It drives inputs only on the falling edge and keeps the fields constant across each strobe. It issues one register access per cycle. It changes `rate_sel` only while all taps are low.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_CMP = 2'd2
    } seq_state_t;

    localparam int REG_W    = 8;
    localparam int N_SRC    = 3;
    localparam int SRC_UF   = 0;
    localparam int SRC_AF   = 1;
    localparam int SRC_PF   = 2;

    localparam int BIT_IRQ  = 7;
    localparam int BIT_PF   = 6;
    localparam int BIT_AF   = 5;
    localparam int BIT_UF   = 4;
    localparam int BIT_RSV  = 3;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;

endpackage

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel #(
    parameter int RATE_W = 4,
    localparam int TAP_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAP_W-1:0]  taps,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [TAP_W-1:0] prev_q;
    logic [TAP_W-1:0] rise;
    logic [TAP_W-1:0] hit;

    // every tap keeps its own history so a rate change cannot fake an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= taps;
        end
    end

    assign rise = taps & ~prev_q;

    // rate value k picks tap k-1; rate zero matches nothing
    for (genvar k = 0; k < TAP_W; k++) begin : g_hit
        assign hit[k] = rise[k] && (rate == RATE_W'(k + 1));
    end

    assign tick = |hit;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELD_W  = 8,
    parameter int N_FIELDS = 5
) (
    input  logic [N_FIELDS-1:0][FIELD_W-1:0] cur,
    input  logic [N_FIELDS-1:0][FIELD_W-1:0] alm,
    output logic                             match
);
    logic [N_FIELDS-1:0] eq;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_eq
        assign eq[i] = (cur[i] == alm[i]);
    end

    assign match = &eq;

endmodule

// File: rtl/rtc_irq_seq.sv
module rtc_irq_seq
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rtc_en,
    input  logic rtc_rst,
    input  logic upd_stb,
    output logic active,
    output logic cmp_slot
);
    seq_state_t state_q;
    seq_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (rtc_rst || !rtc_en) begin
            state_d = ST_OFF;                          // halt
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_RUN;             // go
                ST_RUN:  state_d = upd_stb ? ST_CMP : ST_RUN;
                ST_CMP:  state_d = upd_stb ? ST_CMP : ST_RUN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        active   = 1'b0;
        cmp_slot = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_RUN:  active = 1'b1;
            ST_CMP: begin
                active   = 1'b1;
                cmp_slot = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ev,
    input  logic         stat_rd,
    input  logic         ctrl_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] en_q
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else if (clr[i]) begin
                flag_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                // a new event outranks the clear-on-read
                if (ev[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (stat_rd) begin
                    flag_q[i] <= 1'b0;
                end
                if (ctrl_wr) begin
                    en_q[i] <= en_wdata[i];
                end
            end
        end
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int RATE_W  = 4,
    parameter int FIELD_W = 8,
    localparam int TAP_W  = (1 << RATE_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rtc_rst,
    input  logic               rtc_en,
    input  logic               ram_valid,
    input  logic               upd_stb,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_mon,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_date,
    input  logic [FIELD_W-1:0] alm_mon,
    input  logic [TAP_W-1:0]   div_taps,
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq
);
    localparam int N_FIELDS = 5;

    logic                             active;
    logic                             cmp_slot;
    logic                             tap_tick;
    logic                             alm_match;
    logic                             hold_w;
    logic                             stat_rd_w;
    logic                             ctrl_wr_w;
    logic [N_SRC-1:0]                 ev_w;
    logic [N_SRC-1:0]                 clr_w;
    logic [N_SRC-1:0]                 en_wdata;
    logic [N_SRC-1:0]                 flag_q;
    logic [N_SRC-1:0]                 en_q;
    logic [3:0]                       cfg_q;
    logic [REG_W-1:0]                 ctrl_view;
    logic [REG_W-1:0]                 stat_view;
    logic [REG_W-1:0]                 rdata_q;
    logic [N_FIELDS-1:0][FIELD_W-1:0] cur_v;
    logic [N_FIELDS-1:0][FIELD_W-1:0] alm_v;

    assign cur_v = {cur_mon, cur_date, cur_hour, cur_min, cur_sec};
    assign alm_v = {alm_mon, alm_date, alm_hour, alm_min, alm_sec};

    rtc_irq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rtc_en   (rtc_en),
        .rtc_rst  (rtc_rst),
        .upd_stb  (upd_stb),
        .active   (active),
        .cmp_slot (cmp_slot)
    );

    rtc_tap_sel #(.RATE_W(RATE_W)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (div_taps),
        .rate  (rate_sel),
        .tick  (tap_tick)
    );

    rtc_alarm_cmp #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_cmp (
        .cur   (cur_v),
        .alm   (alm_v),
        .match (alm_match)
    );

    assign hold_w    = rtc_rst || !rtc_en;
    assign stat_rd_w = reg_rd && (reg_sel == SEL_STAT);
    assign ctrl_wr_w = reg_wr && (reg_sel == SEL_CTRL);

    assign ev_w[SRC_UF]  = upd_stb && active;
    assign ev_w[SRC_AF]  = cmp_slot && alm_match && ram_valid;
    assign ev_w[SRC_PF]  = tap_tick && active;

    assign clr_w[SRC_UF] = hold_w;
    assign clr_w[SRC_AF] = !ram_valid;
    assign clr_w[SRC_PF] = hold_w;

    assign en_wdata[SRC_UF] = reg_wdata[BIT_UF];
    assign en_wdata[SRC_AF] = reg_wdata[BIT_AF];
    assign en_wdata[SRC_PF] = reg_wdata[BIT_PF];

    rtc_flag_bank #(.N(N_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_w),
        .ev       (ev_w),
        .stat_rd  (stat_rd_w),
        .ctrl_wr  (ctrl_wr_w),
        .en_wdata (en_wdata),
        .flag_q   (flag_q),
        .en_q     (en_q)
    );

    // control bits 7 and 2:0 are plain storage, power-up reset only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_wr_w) begin
            cfg_q <= {reg_wdata[7], reg_wdata[2:0]};
        end
    end

    assign irq = |(flag_q & en_q);

    always_comb begin
        ctrl_view          = '0;
        ctrl_view[7]       = cfg_q[3];
        ctrl_view[BIT_PF]  = en_q[SRC_PF];
        ctrl_view[BIT_AF]  = en_q[SRC_AF];
        ctrl_view[BIT_UF]  = en_q[SRC_UF];
        ctrl_view[BIT_RSV] = 1'b0;
        ctrl_view[2:0]     = cfg_q[2:0];
    end

    always_comb begin
        stat_view          = '0;
        stat_view[BIT_IRQ] = irq;
        stat_view[BIT_PF]  = flag_q[SRC_PF];
        stat_view[BIT_AF]  = flag_q[SRC_AF];
        stat_view[BIT_UF]  = flag_q[SRC_UF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= (reg_sel == SEL_STAT) ? stat_view : ctrl_view;
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
    import rtc_irq_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_valid,
    input logic              reg_rd,
    input logic              reg_sel,
    input logic [RATE_W-1:0] rate_sel,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq,
    input logic              hold,
    input logic              stat_rd,
    input logic [N_SRC-1:0]  ev,
    input logic [N_SRC-1:0]  flags,
    input logic [N_SRC-1:0]  ens
);
    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_STAT) |=> reg_rdata[BIT_IRQ] == $past(irq)); // R1
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq); // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev == '0) |=> flags == '0); // R2
    AST_AF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[SRC_AF] && ram_valid) |=> flags[SRC_AF]); // R4
    AST_UF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[SRC_UF] && !hold) |=> flags[SRC_UF]); // R5
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!flags[SRC_UF] && !flags[SRC_PF] && !ens[SRC_UF] && !ens[SRC_PF])); // R6
    AST_RAM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_valid |=> (!flags[SRC_AF] && !ens[SRC_AF])); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rdata[BIT_RSV]); // R8
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev[SRC_PF] && !hold) |=> flags[SRC_PF]); // R9
    AST_RATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0 && !flags[SRC_PF]) |=> !flags[SRC_PF]); // R10

endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_valid (ram_valid),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .rate_sel  (rate_sel),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .hold      (hold_w),
    .stat_rd   (stat_rd_w),
    .ev        (ev_w),
    .flags     (flag_q),
    .ens       (en_q)
);

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, rtc_rst, rtc_en, ram_valid, upd_stb;
    logic [7:0]  cur_sec, cur_min, cur_hour, cur_date, cur_mon;
    logic [7:0]  alm_sec, alm_min, alm_hour, alm_date, alm_mon;
    logic [14:0] div_taps;
    logic [3:0]  rate_sel;
    logic        reg_wr, reg_rd, reg_sel;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;
    logic [7:0]  rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rtc_rst(rtc_rst), .rtc_en(rtc_en),
        .ram_valid(ram_valid), .upd_stb(upd_stb),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_mon(cur_mon),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_date(alm_date), .alm_mon(alm_mon),
        .div_taps(div_taps), .rate_sel(rate_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_rd = 1'b1; reg_sel = sel;
        step();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_upd();
        upd_stb = 1'b1;
        step();
        upd_stb = 1'b0;
    endtask

    task automatic alarm_match(input logic on);
        alm_sec = cur_sec; alm_hour = cur_hour; alm_date = cur_date; alm_mon = cur_mon;
        alm_min = on ? cur_min : cur_min + 8'd1;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(1'b1, rv); chk("R2 status after reset", rv, 8'h00);
        rd(1'b0, rv); chk("R8 control after reset", rv, 8'h00);
        rtc_en = 1'b1; ram_valid = 1'b1;
        step();
    endtask

    task automatic t_update();
        wr(1'b0, 8'h10);
        pulse_upd();
        chk("R5 irq after update", {7'd0, irq}, 8'h01);
        step();
        rd(1'b1, rv); chk("R2 status UF+irq", rv, 8'h90);
        chk("R2 irq cleared by read", {7'd0, irq}, 8'h00);
        rd(1'b1, rv); chk("R2 status empty after read", rv, 8'h00);
    endtask

    task automatic t_no_enable();
        wr(1'b0, 8'h00);
        pulse_upd(); step();
        chk("R11 irq masked", {7'd0, irq}, 8'h00);
        rd(1'b1, rv); chk("R11 flag latched without enable", rv, 8'h10);
    endtask

    task automatic t_same_cycle();
        wr(1'b0, 8'h10);
        upd_stb = 1'b1; reg_rd = 1'b1; reg_sel = 1'b1;
        step();
        upd_stb = 1'b0; reg_rd = 1'b0;
        chk("R9 read shows pre-event value", reg_rdata, 8'h00);
        chk("R9 irq kept after colliding read", {7'd0, irq}, 8'h01);
        step();
        rd(1'b1, rv); chk("R9 UF survived", rv, 8'h90);
    endtask

    task automatic t_stat_write();
        wr(1'b0, 8'h00);
        pulse_upd(); step();
        wr(1'b1, 8'hFF);
        rd(1'b0, rv); chk("R8 status write leaves control", rv, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, rv); chk("R8 status write leaves flags", rv, 8'h10);
    endtask

    task automatic t_periodic();
        wr(1'b0, 8'h40);
        rate_sel = 4'd3;
        div_taps[0] = 1'b1; step();
        chk("R3 other tap ignored", {7'd0, irq}, 8'h00);
        div_taps[2] = 1'b1; step();
        chk("R3 selected tap edge", {7'd0, irq}, 8'h01);
        rd(1'b1, rv); chk("R3 status PF", rv, 8'hC0);
        div_taps[2] = 1'b0; div_taps[0] = 1'b0; step();
        rd(1'b1, rv); chk("R3 falling edge ignored", rv, 8'h00);
        rate_sel = 4'd0; step();
        div_taps = 15'h7FFF; step(); step();
        rd(1'b1, rv); chk("R10 rate zero no PF", rv, 8'h00);
        div_taps = '0; step();
    endtask

    task automatic t_alarm();
        wr(1'b0, 8'h20);
        alarm_match(1'b1);
        pulse_upd();
        chk("R4 no AF in strobe cycle", {7'd0, irq}, 8'h00);
        step();
        chk("R4 AF after compare slot", {7'd0, irq}, 8'h01);
        rd(1'b1, rv); chk("R4 status AF+UF", rv, 8'hB0);
        alarm_match(1'b0);
        pulse_upd(); step();
        rd(1'b1, rv); chk("R4 one field differs", rv, 8'h10);
    endtask

    task automatic t_ram_gate();
        alarm_match(1'b1);
        pulse_upd(); step();
        chk("R7 alarm irq before gate", {7'd0, irq}, 8'h01);
        ram_valid = 1'b0; step();
        chk("R7 irq dropped with ram_valid low", {7'd0, irq}, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, rv); chk("R7 AIE held low", rv, 8'h00);
        rd(1'b1, rv); chk("R7 AF held low", rv, 8'h10);
        ram_valid = 1'b1; step();
    endtask

    task automatic t_hold();
        wr(1'b0, 8'hFF);
        rd(1'b0, rv); chk("R8 control layout bit3 zero", rv, 8'hF7);
        pulse_upd(); step();
        rate_sel = 4'd1; div_taps[0] = 1'b1; step();
        div_taps[0] = 1'b0;
        rd(1'b1, rv); chk("R12 all three flags", rv, 8'hF0);
        pulse_upd(); step();
        div_taps[0] = 1'b1; step(); div_taps[0] = 1'b0;
        rtc_rst = 1'b1; step(); rtc_rst = 1'b0;
        rd(1'b0, rv); chk("R6 rtc reset clears PIE UIE only", rv, 8'hA7);
        rd(1'b1, rv); chk("R6 rtc reset keeps AF only", rv, 8'hA0);
        rtc_en = 1'b0; step();
        pulse_upd(); step();
        rd(1'b1, rv); chk("R12 update ignored while off", rv, 8'h00);
        wr(1'b0, 8'h50);
        rd(1'b0, rv); chk("R6 enables blocked while disabled", rv, 8'h00);
        rtc_en = 1'b1; step();
        wr(1'b0, 8'h10);
        pulse_upd();
        chk("R6 running again", {7'd0, irq}, 8'h01);
        step();
        rd(1'b1, rv);
    endtask

    initial begin
        rst_n = 1'b0; rtc_rst = 1'b0; rtc_en = 1'b0; ram_valid = 1'b0; upd_stb = 1'b0;
        cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h08; cur_date = 8'h21; cur_mon = 8'h06;
        alm_sec = 8'hFF; alm_min = 8'hFF; alm_hour = 8'hFF; alm_date = 8'hFF; alm_mon = 8'hFF;
        div_taps = '0; rate_sel = 4'd0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_update();
        t_no_enable();
        t_same_cycle();
        t_stat_write();
        t_periodic();
        t_alarm();
        t_ram_gate();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule